// File: doc/BRIEF.md
# Initiator Transaction Termination Controller

This block belongs to the initiator side of a parallel, multiplexed bus. It decides how each transaction that the initiator starts comes to an end. It watches the target's sampled responses: stop (`stop_n`), claim (`devsel_n`) and ready (`trdy_n`). It also counts the clocks of the address-decode window. From these it produces three outputs: a request to release the frame line, a termination code, and a one-clock completion pulse. The surrounding initiator logic raises `txn_start` in the address-phase clock. It marks special cycles with `special_cyc` and flags its last data phase with `final_beat`. The address and data paths, parity and arbitration are outside this block.

The controller is a five-state machine:

- `ST_IDLE` moves to `ST_DECODE` when it samples `txn_start`.
- `ST_DECODE` waits up to `DECODE_CLKS` clocks for a claim. It moves to `ST_CLAIMED` when the claim line is seen. It moves to `ST_RELEASE` on a stop that comes with the claim. It moves straight to `ST_FINISH` when the final data phase completes, or when the window runs out.
- `ST_CLAIMED` tracks the data phases. It moves to `ST_RELEASE` on any stop, and to `ST_FINISH` when the last data phase completes normally.
- `ST_RELEASE` always moves to `ST_FINISH` on the next clock.
- `ST_FINISH` presents the code and the pulse, then returns to `ST_IDLE`.

Each stop ending is sorted into one of three kinds by the claim line and by whether any data has moved. A claim missing at the end of the decode window gives a master abort. Special cycles are exempt from that timeout.

Top module: `xfer_end_ctrl`

## Requirements
- R1: After reset, `frame_release` and `term_done` are low and `term_code` is 0 (none).
- R2: `txn_start` starts a transaction only in the idle state; a `txn_start` sampled during a running transaction changes neither the timing nor the code of its ending.
- R3: A stop sampled with the claim active and no completed data phase gives code 2 (retry). `frame_release` rises on the clock after the stop is sampled, and `term_done` follows one clock later, so the cycle ends within three clocks of the stop.
- R4: A stop sampled with the claim active gives code 3 (disconnect) when at least one data phase (claim and ready both active) completed earlier or on the same clock.
- R5: A stop sampled with the claim inactive, after the claim had been active in this transaction, gives code 4 (target abort). The release and done timing is the same as in R3.
- R6: During the decode window, a stop sampled while the claim has never been active is ignored, and the window continues.
- R7: With `txn_start` sampled at clock edge 0, the claim is sampled at edges 1 to 4 (`DECODE_CLKS`=4). If it is absent at all of them, then after edge 4 `term_done` and `frame_release` are high with code 5 (master abort).
- R8: A claim first seen at the last decode edge (edge 4) prevents the master abort, and the transaction continues.
- R9: A special cycle never produces code 5. When no claim comes, it ends with code 1 (normal), at the time a master abort would have fired.
- R10: A data phase with claim and ready active, `final_beat` high and stop inactive gives code 1 (normal). `term_done` and `frame_release` are high after that same edge.
- R11: `term_done` lasts exactly one clock. `term_code` is 0 whenever `term_done` is low. The block is idle on the following clock and accepts a new `txn_start` there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Address phase of a new transaction this clock |
| special_cyc | input | 1 | Transaction is a special cycle (sampled with `txn_start`) |
| stop_n | input | 1 | Sampled target stop, active low |
| devsel_n | input | 1 | Sampled target claim, active low |
| trdy_n | input | 1 | Sampled target ready, active low |
| final_beat | input | 1 | Current data phase is the initiator's last |
| frame_release | output | 1 | Request to deassert the frame line |
| term_code | output | 3 | 0 none, 1 normal, 2 retry, 3 disconnect, 4 target abort, 5 master abort |
| term_done | output | 1 | One-clock completion pulse |

## Verification
A wrong state in this machine shows at the ports within one or two clocks. A missed stop or a stuck `ST_RELEASE` breaks the release-then-done sequence on the clock after the stop. A miscounted decode window moves the master-abort pulse by a whole clock, or makes it appear for a special cycle. A lost data-seen flag turns a disconnect into a retry in the single `term_done` clock. Random transactions vary the claim clock, the wait states, the data count and the stray start and stop pulses. Directed cases pin down the edge-4 claim, stops on the first claimed clock and special cycles.

// File: rtl/xfer_end_pkg.sv
package xfer_end_pkg;

    typedef enum logic [2:0] {
        TC_NONE   = 3'd0,
        TC_NORMAL = 3'd1,
        TC_RETRY  = 3'd2,
        TC_DISCON = 3'd3,
        TC_TABORT = 3'd4,
        TC_MABORT = 3'd5
    } term_code_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_CLAIMED,
        ST_RELEASE,
        ST_FINISH
    } xe_state_e;

endpackage

// File: rtl/xe_decode_timer.sv
module xe_decode_timer #(
    parameter int DECODE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic window_last
);
    localparam int CW = $clog2(DECODE_CLKS + 1);
    localparam logic [CW-1:0] LAST = CW'(DECODE_CLKS);

    logic [CW-1:0] cnt_q;

    // cnt_q holds the index of the decode edge about to be sampled
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= CW'(1);
        end else if (run && cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign window_last = run && (cnt_q == LAST);

endmodule

// File: rtl/xe_stop_sort.sv
module xe_stop_sort
    import xfer_end_pkg::*;
(
    input  logic       stop_act,
    input  logic       sel_act,
    input  logic       rdy_act,
    input  logic       last_act,
    input  logic       seen_data,
    input  logic       claimed,
    output term_code_e verdict
);
    always_comb begin
        verdict = TC_NONE;
        if (stop_act && sel_act) begin
            verdict = (seen_data || rdy_act) ? TC_DISCON : TC_RETRY;
        end else if (stop_act && claimed) begin
            verdict = TC_TABORT;
        end else if (!stop_act && sel_act && rdy_act && last_act) begin
            verdict = TC_NORMAL;
        end
    end

endmodule

// File: rtl/xfer_end_ctrl.sv
module xfer_end_ctrl
    import xfer_end_pkg::*;
#(
    parameter int DECODE_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       txn_start,
    input  logic       special_cyc,
    input  logic       stop_n,
    input  logic       devsel_n,
    input  logic       trdy_n,
    input  logic       final_beat,
    output logic       frame_release,
    output logic [2:0] term_code,
    output logic       term_done
);
    xe_state_e  state_q, state_d;
    term_code_e code_q, code_d;
    term_code_e verdict;
    logic       spec_q;
    logic       seen_q;
    logic       window_last;
    logic       active;

    wire stop_act = !stop_n;
    wire sel_act  = !devsel_n;
    wire rdy_act  = !trdy_n;

    assign active = (state_q == ST_DECODE) || (state_q == ST_CLAIMED);

    xe_decode_timer #(.DECODE_CLKS(DECODE_CLKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (state_q == ST_IDLE),
        .run         (state_q == ST_DECODE),
        .window_last (window_last)
    );

    xe_stop_sort u_sort (
        .stop_act  (stop_act),
        .sel_act   (sel_act),
        .rdy_act   (rdy_act),
        .last_act  (final_beat),
        .seen_data (seen_q),
        .claimed   (state_q == ST_CLAIMED),
        .verdict   (verdict)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= TC_NONE;
            spec_q  <= 1'b0;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
            if (state_q == ST_IDLE && txn_start) begin
                spec_q <= special_cyc;
                seen_q <= 1'b0;
            end else if (active && sel_act && rdy_act) begin
                seen_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ST_IDLE: begin
                if (txn_start) begin
                    state_d = ST_DECODE;
                    code_d  = TC_NONE;
                end
            end
            ST_DECODE: begin
                if (verdict != TC_NONE) begin
                    state_d = (verdict == TC_NORMAL) ? ST_FINISH : ST_RELEASE;
                    code_d  = verdict;
                end else if (sel_act) begin
                    state_d = ST_CLAIMED;
                end else if (window_last) begin
                    state_d = ST_FINISH;
                    code_d  = spec_q ? TC_NORMAL : TC_MABORT;
                end
            end
            ST_CLAIMED: begin
                if (verdict != TC_NONE) begin
                    state_d = (verdict == TC_NORMAL) ? ST_FINISH : ST_RELEASE;
                    code_d  = verdict;
                end
            end
            ST_RELEASE: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        frame_release = (state_q == ST_RELEASE) || (state_q == ST_FINISH);
        term_done     = (state_q == ST_FINISH);
        term_code     = (state_q == ST_FINISH) ? code_q : TC_NONE;
    end

endmodule

// File: rtl/xfer_end_chk.sv
module xfer_end_chk
    import xfer_end_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       stop_n,
    input logic       devsel_n,
    input logic       frame_release,
    input logic [2:0] term_code,
    input logic       term_done,
    input xe_state_e  state,
    input logic       spec_q,
    input logic       seen_q
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        term_done |=> !term_done);                                   // R11
    AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !term_done |-> term_code == TC_NONE);                        // R11
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        term_done |=> state == ST_IDLE);                             // R11
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        term_done |-> frame_release);                                // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLAIMED && !stop_n) |=> frame_release);         // R3
    AST_RELEASE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_release && !term_done) |=> term_done);                // R3
    AST_RETRY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (term_done && term_code == TC_RETRY) |-> !seen_q);           // R3
    AST_UNCLAIMED_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && !stop_n && devsel_n)
            |=> (!frame_release || term_done));                      // R6
    AST_SPECIAL_NO_MABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (term_done && spec_q) |-> term_code != TC_MABORT);           // R9
endmodule

bind xfer_end_ctrl xfer_end_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_n        (stop_n),
    .devsel_n      (devsel_n),
    .frame_release (frame_release),
    .term_code     (term_code),
    .term_done     (term_done),
    .state         (state_q),
    .spec_q        (spec_q),
    .seen_q        (seen_q)
);

// File: tb/xfer_end_ctrl_test.sv
`timescale 1ns/1ps
module xfer_end_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       txn_start = 1'b0;
    logic       special_cyc = 1'b0;
    logic       stop_n = 1'b1;
    logic       devsel_n = 1'b1;
    logic       trdy_n = 1'b1;
    logic       final_beat = 1'b0;
    logic       frame_release;
    logic [2:0] term_code;
    logic       term_done;

    int checks = 0;
    int errors = 0;

    localparam int K_NORMAL = 0;
    localparam int K_STOP   = 1;
    localparam int K_TABORT = 2;

    always #10 clk = ~clk;

    xfer_end_ctrl #(.DECODE_CLKS(4)) uut (
        .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .special_cyc(special_cyc),
        .stop_n(stop_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .final_beat(final_beat),
        .frame_release(frame_release), .term_code(term_code), .term_done(term_done)
    );

    function automatic logic [2:0] window_code(input logic sp);
        return sp ? 3'd1 : 3'd5;
    endfunction

    function automatic logic [2:0] stop_code(input int beats, input logic rdy, input logic abort);
        if (abort) return 3'd4;
        return (beats > 0 || rdy) ? 3'd3 : 3'd2;
    endfunction

    task automatic tick(input logic st, input logic stp, input logic sel,
                        input logic rdy, input logic fin);
        txn_start  = st;
        stop_n     = !stp;
        devsel_n   = !sel;
        trdy_n     = !rdy;
        final_beat = fin;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input logic d, input logic r, input logic [2:0] c,
                              input string tag);
        checks++;
        if (term_done !== d || frame_release !== r || term_code !== c) begin
            errors++;
            $display("FAIL %s: done/release/code = %0b/%0b/%0d, expected %0b/%0b/%0d",
                     tag, term_done, frame_release, term_code, d, r, c);
        end
    endtask

    // sel_at: decode edge of first claim (1..4) or 0 for none
    task automatic run_txn(input logic sp, input int sel_at, input int kind,
                           input int nbeats, input logic rdy_on_stop, input logic noise);
        logic [2:0] ec;
        int last_dec;
        special_cyc = sp;
        tick(1, 0, 0, 0, 0);
        expect_out(0, 0, 3'd0, "R2 start accepted");
        last_dec = (sel_at == 0) ? 4 : sel_at - 1;
        for (int c = 1; c <= last_dec; c++) begin
            tick(noise & 1'($urandom_range(0, 1)), noise & 1'($urandom_range(0, 1)), 0, 0, 0);
            if (c == 4) expect_out(1, 1, window_code(sp), sp ? "R9 special no abort" : "R7 master abort");
            else        expect_out(0, 0, 3'd0, "R6 unclaimed stop ignored");
        end
        if (sel_at == 0) begin
            tick(0, 0, 0, 0, 0);
            expect_out(0, 0, 3'd0, "R11 idle after done");
            return;
        end
        for (int b = 0; b < nbeats; b++) begin
            int w;
            logic lastb;
            w = $urandom_range(0, 2);
            for (int k = 0; k < w; k++) begin
                tick(noise & 1'($urandom_range(0, 1)), 0, 1, 0, 0);
                expect_out(0, 0, 3'd0, "R2 busy wait state");
            end
            lastb = (kind == K_NORMAL) && (b == nbeats - 1);
            tick(noise & 1'($urandom_range(0, 1)), 0, 1, 1, lastb);
            if (lastb) expect_out(1, 1, 3'd1, "R10 normal end");
            else       expect_out(0, 0, 3'd0, "R8 claimed data beat");
        end
        if (kind == K_NORMAL) begin
            tick(0, 0, 0, 0, 0);
            expect_out(0, 0, 3'd0, "R11 idle after done");
            return;
        end
        if (kind == K_TABORT) begin
            if (nbeats == 0) begin
                tick(0, 0, 1, 0, 0);
                expect_out(0, 0, 3'd0, "R5 claim before abort");
            end
            tick(noise & 1'($urandom_range(0, 1)), 1, 0, 0, 0);
            ec = stop_code(nbeats, 1'b0, 1'b1);
            expect_out(0, 1, 3'd0, "R5 release after stop");
        end else begin
            tick(noise & 1'($urandom_range(0, 1)), 1, 1, rdy_on_stop, 0);
            ec = stop_code(nbeats, rdy_on_stop, 1'b0);
            expect_out(0, 1, 3'd0, "R3 release after stop");
        end
        tick(0, 0, 0, 0, 0);
        expect_out(1, 1, ec, (ec == 3'd2) ? "R3 retry" : (ec == 3'd3) ? "R4 disconnect" : "R5 target abort");
        tick(0, 0, 0, 0, 0);
        expect_out(0, 0, 3'd0, "R11 one-clock done");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        @(negedge clk);
        tick(0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0);
        expect_out(0, 0, 3'd0, "R1 reset state");
        rst_n = 1'b1;
        tick(0, 0, 0, 0, 0);
        expect_out(0, 0, 3'd0, "R1 idle after reset");

        // directed corners
        run_txn(0, 0, K_NORMAL, 0, 0, 0);   // master abort
        run_txn(1, 0, K_NORMAL, 0, 0, 0);   // special, no claim
        run_txn(0, 0, K_NORMAL, 0, 0, 1);   // stray stops in window
        run_txn(0, 4, K_NORMAL, 2, 0, 0);   // claim on last decode edge
        run_txn(1, 4, K_NORMAL, 1, 0, 0);
        run_txn(0, 1, K_STOP,   0, 0, 0);   // retry on first claimed edge
        run_txn(0, 2, K_STOP,   0, 1, 0);   // disconnect with data on stop edge
        run_txn(0, 3, K_STOP,   3, 0, 1);   // disconnect after data
        run_txn(0, 1, K_TABORT, 0, 0, 0);
        run_txn(0, 4, K_TABORT, 2, 0, 1);
        run_txn(0, 1, K_NORMAL, 1, 0, 1);

        // constrained random
        for (int i = 0; i < 120; i++) begin
            int kind;
            int nb;
            kind = $urandom_range(0, 2);
            nb   = $urandom_range(0, 4);
            if (kind == K_NORMAL && nb == 0) nb = 1;
            run_txn(1'($urandom_range(0, 1)), $urandom_range(0, 4), kind, nb,
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule